// File: doc/BRIEF.md
# Address-Match Breakpoint Unit

This unit is a debug aid for a small 8-bit processor. It watches the processor's 16-bit bus address. When breaks are enabled and a valid bus access hits the programmed break address, it latches an active flag and raises a break interrupt request. The request stays up until software clears the flag from the break handler. Software can also force a break by writing 1 to the active flag, with or without an address match.

The unit keeps a second, sticky flag that records a break taken while the processor sat in its low-power stop state. The handler reads this flag to tell a stop wake-up caused by a break apart from other wake-up causes. While stopped, a pending break also drives a wake-up output. Four byte-wide registers sit on a simple register bus: control/status, break address high byte, break address low byte and stop-break status. Writes are strobed. Read data is combinational on the selected register.

Top module: `brkpt_unit`

## Requirements
- R1: An active-low reset clears the enable bit, the active flag, both break address bytes (to 0x00) and the stop-break flag. After reset, brk_irq and wake are low.
- R2: reg_sel selects a register: 0 is control/status, 1 is the break address high byte (address bits 15:8), 2 is the low byte (bits 7:0), and 3 is stop-break status. Each address byte reads back the last value written to it.
- R3: Control bits 5:0 and stop-status bits 7:2 and 0 always read 0, whatever is written to them.
- R4: While enable (control bit 7) is 1, a valid bus access whose full 16-bit address equals the break address sets the active flag (control bit 6) at that clock edge. brk_irq is high from the next cycle.
- R5: No break is taken when enable is 0, when bus_valid is 0, or when only one address byte matches.
- R6: A write of 1 to control bit 6 sets the active flag and raises brk_irq, whatever the enable bit or the bus address.
- R7: brk_irq stays high as long as the active flag is 1. A write of 0 to bit 6 clears it, and brk_irq is low in the next cycle. A break event in the same cycle as that clearing write takes priority, and the flag stays set.
- R8: wake is high exactly while stop_mode is high and the active flag is 1.
- R9: A break event (a match or a forced write) while stop_mode is high sets the stop-break flag (status bit 1). Without stop_mode the flag is not set. The flag is sticky: clearing the active flag leaves it set, a write of 1 has no effect, and a write of 0 to bit 1 clears it.
- R10: Control bit 7 holds the written enable value and reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| bus_valid | input | 1 | Processor bus access valid this cycle |
| bus_addr | input | 16 | Processor bus address |
| stop_mode | input | 1 | Processor is in stop state |
| brk_irq | output | 1 | Break interrupt request |
| wake | output | 1 | Wake-up request from stop state |

## Verification
The assertions assume that reg_sel, reg_wr, reg_wdata, bus_valid, bus_addr and stop_mode are known and settled at each rising clock edge. They also assume that reg_wr lasts a single cycle for each intended write, so one write strobe means one register update. The bench changes every input one time unit after the rising edge and holds it through the next edge. Each register write lasts exactly one cycle, and bus accesses pulse bus_valid for one cycle. All outputs are compared at the falling edge, so no stimulus ever changes at a sampling point.

// File: rtl/brkpt_pkg.sv
package brkpt_pkg;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_ADRH = 2'd1,
      SEL_ADRL = 2'd2,
      SEL_STOP = 2'd3
   } reg_sel_e;

   localparam int SEL_W = 2;

endpackage

// File: rtl/brkpt_cmp.sv
module brkpt_cmp #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter bit SLICED = 1'b1
) (
   input  logic              enable,
   input  logic              bus_valid,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [ADDR_W-1:0] brk_addr,
   output logic              hit
);

   localparam int NBYTES = ADDR_W / DATA_W;

   logic eq;

   generate
      if (SLICED) begin : g_sliced
         logic [NBYTES-1:0] byte_eq;
         for (genvar b = 0; b < NBYTES; b++) begin : g_byte
            assign byte_eq[b] = (bus_addr[b*DATA_W +: DATA_W] == brk_addr[b*DATA_W +: DATA_W]);
         end
         assign eq = &byte_eq;
      end else begin : g_flat
         assign eq = (bus_addr == brk_addr);
      end
   endgenerate

   assign hit = enable & bus_valid & eq;

endmodule

// File: rtl/brkpt_regs.sv
module brkpt_regs
   import brkpt_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 8,
   parameter int STOP_BIT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  sel,
   input  logic [DATA_W-1:0] wdata,
   input  logic              hit,
   input  logic              stop_flag,
   output logic [DATA_W-1:0] rdata,
   output logic              enable,
   output logic              active,
   output logic [ADDR_W-1:0] brk_addr,
   output logic              set_evt,
   output logic              stop_clr
);

   localparam int EN_BIT  = DATA_W - 1;
   localparam int ACT_BIT = DATA_W - 2;

   reg_sel_e sel_e;
   logic     wr_ctrl, wr_hi, wr_lo, wr_stop;
   logic     force_set;
   logic [DATA_W-1:0] adr_hi, adr_lo;

   assign sel_e   = reg_sel_e'(sel);
   assign wr_ctrl = wr_en && (sel_e == SEL_CTRL);
   assign wr_hi   = wr_en && (sel_e == SEL_ADRH);
   assign wr_lo   = wr_en && (sel_e == SEL_ADRL);
   assign wr_stop = wr_en && (sel_e == SEL_STOP);

   assign force_set = wr_ctrl && wdata[ACT_BIT];
   assign set_evt   = hit || force_set;
   assign stop_clr  = wr_stop && !wdata[STOP_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable <= 1'b0;
         active <= 1'b0;
         adr_hi <= '0;
         adr_lo <= '0;
      end else begin
         if (wr_ctrl) enable <= wdata[EN_BIT];
         if (set_evt)
            active <= 1'b1;
         else if (wr_ctrl)
            active <= 1'b0;
         if (wr_hi) adr_hi <= wdata;
         if (wr_lo) adr_lo <= wdata;
      end
   end

   assign brk_addr = {adr_hi, adr_lo};

   always_comb begin
      rdata = '0;
      unique case (sel_e)
         SEL_CTRL: begin
            rdata[EN_BIT]  = enable;
            rdata[ACT_BIT] = active;
         end
         SEL_ADRH: rdata = adr_hi;
         SEL_ADRL: rdata = adr_lo;
         SEL_STOP: rdata[STOP_BIT] = stop_flag;
         default:  rdata = '0;
      endcase
   end

   AST_HIT_SETS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> active); // R4
   AST_FORCE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && wdata[ACT_BIT]) |=> active); // R6
   AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !wdata[ACT_BIT] && !hit) |=> !active); // R7
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !hit && !wr_ctrl) |=> !active); // R5
   AST_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ctrl |=> $stable(enable)); // R10

endmodule

// File: rtl/brkpt_stop.sv
module brkpt_stop (
   input  logic clk,
   input  logic rst_n,
   input  logic set_evt,
   input  logic stop_mode,
   input  logic stop_clr,
   input  logic active,
   output logic stop_flag,
   output logic wake
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         stop_flag <= 1'b0;
      else if (set_evt && stop_mode)
         stop_flag <= 1'b1;
      else if (stop_clr)
         stop_flag <= 1'b0;
   end

   assign wake = stop_mode & active;

   AST_STOPFLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_flag && !stop_clr) |=> stop_flag); // R9
   AST_STOPFLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (set_evt && stop_mode) |=> stop_flag); // R9
   AST_STOPFLAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!stop_flag && !stop_mode) |=> !stop_flag); // R9

endmodule

// File: rtl/brkpt_unit.sv
module brkpt_unit
   import brkpt_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 8,
   parameter int STOP_BIT = 1,
   parameter bit SLICED   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        reg_sel,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              bus_valid,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              stop_mode,
   output logic              brk_irq,
   output logic              wake
);

   generate
      if (ADDR_W != 2 * DATA_W) begin : g_bad_width
         $error("break address must be exactly two register bytes wide");
      end
      if (DATA_W < 3 || STOP_BIT < 1 || STOP_BIT >= DATA_W) begin : g_bad_stop
         $error("stop flag position or register width out of range");
      end
   endgenerate

   logic              enable, active, hit, set_evt, stop_clr, stop_flag;
   logic [ADDR_W-1:0] brk_addr;

   brkpt_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLICED(SLICED)) cmp_i (
      .enable   (enable),
      .bus_valid(bus_valid),
      .bus_addr (bus_addr),
      .brk_addr (brk_addr),
      .hit      (hit)
   );

   brkpt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STOP_BIT(STOP_BIT)) regs_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr),
      .sel      (reg_sel),
      .wdata    (reg_wdata),
      .hit      (hit),
      .stop_flag(stop_flag),
      .rdata    (reg_rdata),
      .enable   (enable),
      .active   (active),
      .brk_addr (brk_addr),
      .set_evt  (set_evt),
      .stop_clr (stop_clr)
   );

   brkpt_stop stop_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_evt  (set_evt),
      .stop_mode(stop_mode),
      .stop_clr (stop_clr),
      .active   (active),
      .stop_flag(stop_flag),
      .wake     (wake)
   );

   assign brk_irq = active;

   AST_MATCH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && bus_valid && (bus_addr == brk_addr)) |=> brk_irq); // R4
   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!brk_irq && !enable && !reg_wr) |=> !brk_irq); // R5
   AST_WAKE_NEEDS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> (stop_mode && brk_irq)); // R8

endmodule

// File: tb/brkpt_unit_tb_top.sv
module brkpt_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_wdata = 8'h00;
   logic [7:0]  reg_rdata;
   logic        bus_valid = 1'b0;
   logic [15:0] bus_addr = 16'h0000;
   logic        stop_mode = 1'b0;
   logic        brk_irq, wake;

   always #5 clk = ~clk;

   brkpt_unit dut_i (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
      .bus_addr(bus_addr), .stop_mode(stop_mode), .brk_irq(brk_irq), .wake(wake)
   );

   typedef struct {
      int         kind;
      logic [7:0] exp;
      string      tag;
   } exp_item_t;

   exp_item_t sb_q[$];
   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always @(negedge clk) begin
      while (sb_q.size() > 0) begin
         exp_item_t it;
         logic [7:0] act;
         it = sb_q.pop_front();
         case (it.kind)
            0:       act = reg_rdata;
            1:       act = {7'd0, brk_irq};
            default: act = {7'd0, wake};
         endcase
         n_vec++;
         if (act !== it.exp) begin
            n_bad++;
            $display("FAIL %s: kind %0d actual %02h expected %02h", it.tag, it.kind, act, it.exp);
         end
      end
   end

   task automatic push(input int kind, input logic [7:0] exp, input string tag);
      exp_item_t it;
      it.kind = kind; it.exp = exp; it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic chk_reg(input logic [1:0] sel, input logic [7:0] exp, input string tag);
      @(posedge clk); #1;
      reg_sel = sel;
      push(0, exp, tag);
   endtask

   task automatic chk_out(input logic irq_e, input logic wake_e, input string tag);
      @(posedge clk); #1;
      push(1, {7'd0, irq_e}, tag);
      push(2, {7'd0, wake_e}, tag);
   endtask

   task automatic wr(input logic [1:0] sel, input logic [7:0] d);
      @(posedge clk); #1;
      reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic bus(input logic [15:0] a, input logic v);
      @(posedge clk); #1;
      bus_addr = a; bus_valid = v;
      @(posedge clk); #1;
      bus_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 and R3: reset state
      chk_reg(2'd0, 8'h00, "R1 ctrl");
      chk_reg(2'd1, 8'h00, "R1 adrh");
      chk_reg(2'd2, 8'h00, "R1 adrl");
      chk_reg(2'd3, 8'h00, "R1 stop");
      chk_out(1'b0, 1'b0, "R1 outputs");
      // R2: address bytes
      wr(2'd1, 8'h12);
      wr(2'd2, 8'h34);
      chk_reg(2'd1, 8'h12, "R2 adrh");
      chk_reg(2'd2, 8'h34, "R2 adrl");
      // R5: disabled
      bus(16'h1234, 1'b1);
      chk_out(1'b0, 1'b0, "R5 disabled");
      // R10 and R3: enable with junk low bits
      wr(2'd0, 8'hBF);
      chk_reg(2'd0, 8'h80, "R10 R3 ctrl");
      wr(2'd3, 8'hFD);
      chk_reg(2'd3, 8'h00, "R3 stop bits");
      // R5: invalid access and partial matches
      bus(16'h1234, 1'b0);
      chk_out(1'b0, 1'b0, "R5 no valid");
      bus(16'h1235, 1'b1);
      chk_out(1'b0, 1'b0, "R5 low differs");
      bus(16'h1334, 1'b1);
      chk_out(1'b0, 1'b0, "R5 high differs");
      // R4: full match
      bus(16'h1234, 1'b1);
      chk_out(1'b1, 1'b0, "R4 irq");
      chk_reg(2'd0, 8'hC0, "R4 ctrl");
      repeat (4) chk_out(1'b1, 1'b0, "R7 holds");
      // R7: clear
      wr(2'd0, 8'h80);
      chk_out(1'b0, 1'b0, "R7 cleared");
      chk_reg(2'd0, 8'h80, "R7 ctrl");
      // R7: set beats clear
      wr(2'd0, 8'hC0);
      @(posedge clk); #1;
      reg_sel = 2'd0; reg_wdata = 8'h80; reg_wr = 1'b1;
      bus_addr = 16'h1234; bus_valid = 1'b1;
      @(posedge clk); #1;
      reg_wr = 1'b0; bus_valid = 1'b0;
      chk_out(1'b1, 1'b0, "R7 set priority");
      // R6: forced break while disabled
      wr(2'd0, 8'h00);
      chk_out(1'b0, 1'b0, "R6 pre");
      wr(2'd0, 8'h40);
      chk_out(1'b1, 1'b0, "R6 forced");
      chk_reg(2'd0, 8'h40, "R6 ctrl");
      wr(2'd0, 8'h00);
      // R9: match outside stop leaves stop flag clear
      wr(2'd0, 8'h80);
      bus(16'h1234, 1'b1);
      chk_reg(2'd3, 8'h00, "R9 not stopped");
      wr(2'd0, 8'h80);
      // R8 R9: break while stopped
      @(posedge clk); #1 stop_mode = 1'b1;
      chk_out(1'b0, 1'b0, "R8 idle stop");
      bus(16'h1234, 1'b1);
      chk_out(1'b1, 1'b1, "R8 wake");
      chk_reg(2'd3, 8'h02, "R9 set");
      wr(2'd3, 8'h02);
      chk_reg(2'd3, 8'h02, "R9 write one");
      wr(2'd0, 8'h80);
      chk_out(1'b0, 1'b0, "R8 wake drop");
      chk_reg(2'd3, 8'h02, "R9 sticky");
      wr(2'd3, 8'h00);
      chk_reg(2'd3, 8'h00, "R9 clear");
      wr(2'd0, 8'h40);
      chk_reg(2'd3, 8'h02, "R9 forced");
      @(posedge clk); #1 stop_mode = 1'b0;
      chk_out(1'b1, 1'b0, "R8 no stop");
      // R1: reset mid-run
      @(posedge clk); #1 rst_n = 1'b0;
      chk_out(1'b0, 1'b0, "R1 rerun outputs");
      chk_reg(2'd0, 8'h00, "R1 rerun ctrl");
      chk_reg(2'd1, 8'h00, "R1 rerun adrh");
      chk_reg(2'd3, 8'h00, "R1 rerun stop");
      @(posedge clk); #1 rst_n = 1'b1;
      repeat (2) @(posedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule